// File: doc/BRIEF.md
# Multi-Mode Serial Channel

One serial channel with three personalities picked by a 2-bit mode field. It can frame 7-bit or 8-bit asynchronous characters, or it can move 8-bit words over a clocked link as either the clock master or the clock slave. In the asynchronous modes the bit timing comes from an input clock. That clock is either a one-cycle pulse from an outside programmable timer or the rising edges of the external serial clock pin. The input clock is divided by 8 or by 16 to give one bit period, and the receiver checks each bit at the centre of its period.

Software programs the mode, the clock source and the oversampling ratio with one write strobe, and reads them back on dedicated outputs. Data moves over two valid/ready streams. The transmit stream accepts a word only while the shifter is idle, so `tx_ready` doubles as the transmit-empty flag. The receive stream raises `rx_valid` as the receive-full flag and holds the word and `rx_valid` until the consumer asserts `rx_ready`. A word that completes while the previous one is still unread replaces it and sets a sticky overrun flag, so back-pressure on the receive side loses data rather than stalling the line. Framing and overrun flags stay set until the next configuration write.

Top module: `sio_channel`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_valid`=0, `txd`=1, `sclk_oe`=0, both error flags are 0, and the configuration reads back mode 2'b11, clock select 0 and divide select 0.
- R2: A cycle with `cfg_wr`=1 stores mode, clock select and divide select, which then appear on the readback outputs. The same write clears `frame_err` and `overrun`.
- R3: Mode encoding: 2'b11 = 8-bit asynchronous, 2'b10 = 7-bit asynchronous, 2'b01 = synchronous slave, 2'b00 = synchronous master.
- R4: An asynchronous frame is one low start bit, the data bits LSB first, and one high stop bit. `txd` is high whenever the transmitter is idle.
- R5: With clock select 0, the asynchronous input clock is `baud_tick`. With clock select 1, it is each rising edge of `sclk_in` after a two-flop synchronizer.
- R6: Divide select 1 gives 8 input-clock pulses per bit, and 0 gives 16.
- R7: In 7-bit mode, `tx_data[7]` is not transmitted (the stop bit follows data bit 6), and `rx_data[7]` reads 0.
- R8: The receiver starts on a falling edge of the synchronized `rxd` and confirms the start bit after half a bit period (4 of 8 or 8 of 16 pulses). A low pulse shorter than that yields no word.
- R9: A stop bit sampled low sets `frame_err`. The word is still delivered.
- R10: A word that completes while `rx_valid`=1 and `rx_ready`=0 sets `overrun`, and `rx_data` takes the new word.
- R11: In master mode `sclk_oe`=1. While a word is in flight, `sclk_out` toggles on each `baud_tick`: it idles high, `txd` changes on falling edges, and `rxd` is sampled on rising edges. Each word has 8 rising edges, LSB first.
- R12: In slave mode `sclk_oe`=0. Bit 0 is on `txd` from the moment the word is loaded. The shifter advances on falling edges of the synchronized `sclk_in` and samples `rxd` on its rising edges, and 8 rising edges complete a word.
- R13: A transmit word is taken on a cycle with `tx_valid`=1 and `tx_ready`=1, after which `tx_ready` is low until the shifter finishes. `rx_valid` stays high with stable data until `rx_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode to store (R3 encoding) |
| cfg_ext_clk_i | input | 1 | Clock select to store: 1 = `sclk_in`, 0 = `baud_tick` |
| cfg_div8_i | input | 1 | Divide select to store: 1 = /8, 0 = /16 |
| cfg_mode_o | output | 2 | Stored mode |
| cfg_ext_clk_o | output | 1 | Stored clock select |
| cfg_div8_o | output | 1 | Stored divide select |
| baud_tick | input | 1 | One-cycle pulse from the outside timer |
| sclk_in | input | 1 | External serial clock pin (asynchronous input) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in (asynchronous input) |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Shifter idle, transmit word accepted |
| tx_data | input | DW | Transmit word |
| rx_valid | output | 1 | Receive word held |
| rx_ready | input | 1 | Consumer takes the held word |
| rx_data | output | DW | Receive word |
| frame_err | output | 1 | Sticky: stop bit was low |
| overrun | output | 1 | Sticky: unread word was overwritten |

## Verification
A bad bit counter or oversampling counter shows within one frame. The bit on `txd` sampled at mid-period comes out wrong or the stop bit lands in the wrong slot, and a looped-back word differs from the one sent. A receiver that confirms its start bit at the wrong point either accepts a short glitch as a word or misaligns every later sample, and `rx_data` is wrong one frame later. A corrupt synchronous state shows within a single word, either as a count other than 8 on `sclk_out` or as `sclk_out` left low at rest. A broken receive buffer shows on the next completion, through `overrun`, `rx_valid` or the held data.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC_MASTER = 2'b00,
    MODE_SYNC_SLAVE  = 2'b01,
    MODE_ASYNC7      = 2'b10,
    MODE_ASYNC8      = 2'b11
  } sio_mode_e;

  function automatic logic mode_is_async(sio_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/sio_line_sync.sv
module sio_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= {(STAGES+1){RST_VAL}};
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign q      = sh[STAGES-1];
  assign q_prev = sh[STAGES];
endmodule

// File: rtl/sio_async_tx.sv
module sio_async_tx #(
  parameter int DW    = 8,
  parameter int OS_LO = 8,
  parameter int OS_HI = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          div8,
  input  logic          seven,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          txd
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(OS_HI);
  localparam int LW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(OS_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(OS_HI - 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic [LW-1:0] left;
  logic [CW-1:0] last;

  assign last = div8 ? LAST_LO : LAST_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      tcnt <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (start && !busy) begin
      sh   <= seven ? {2'b11, data[DW-2:0], 1'b0} : {1'b1, data, 1'b0};
      left <= seven ? LW'(FW - 1) : LW'(FW);
      tcnt <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == last) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
        if (left == LW'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd = sh[0];

  assert_tx_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_tick_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt <= last));
endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx #(
  parameter int DW    = 8,
  parameter int OS_LO = 8,
  parameter int OS_HI = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          div8,
  input  logic          seven,
  input  logic          rxd,
  input  logic          rxd_fall,
  output logic          done,
  output logic          ferr,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(OS_HI);
  localparam int NW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(OS_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(OS_HI - 1);
  localparam logic [CW-1:0] HALF_LO = CW'(OS_LO / 2 - 1);
  localparam logic [CW-1:0] HALF_HI = CW'(OS_HI / 2 - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;

  rx_st_e        st;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] nb;
  logic [DW-1:0] sh;
  logic [CW-1:0] last, half;
  logic [NW-1:0] nb_last;

  assign last    = div8 ? LAST_LO : LAST_HI;
  assign half    = div8 ? HALF_LO : HALF_HI;
  assign nb_last = seven ? NW'(DW - 2) : NW'(DW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= R_IDLE;
      tcnt <= '0;
      nb   <= '0;
      sh   <= '0;
      done <= 1'b0;
      ferr <= 1'b0;
      data <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= R_IDLE;
      end else begin
        case (st)
          R_IDLE: if (rxd_fall) begin
            st   <= R_START;
            tcnt <= '0;
          end
          R_START: if (tick) begin
            if (tcnt == half) begin
              if (!rxd) begin
                st   <= R_DATA;
                tcnt <= '0;
                nb   <= '0;
              end else begin
                st <= R_IDLE;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          R_DATA: if (tick) begin
            if (tcnt == last) begin
              tcnt <= '0;
              sh   <= {rxd, sh[DW-1:1]};
              nb   <= nb + 1'b1;
              if (nb == nb_last) st <= R_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          default: if (tick) begin
            if (tcnt == last) begin
              st   <= R_IDLE;
              done <= 1'b1;
              ferr <= !rxd;
              data <= seven ? {1'b0, sh[DW-1:1]} : sh;
            end else tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end

  assert_done_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == R_STOP));
  assert_seven_msb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && seven) |-> !data[DW-1]);
endmodule

// File: rtl/sio_sync_eng.sv
module sio_sync_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          tick,
  input  logic          ext_rise,
  input  logic          ext_fall,
  input  logic          rxd,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          txd,
  output logic          sclk_o,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int CNW = $clog2(DW);

  logic [DW-1:0]  tsh, rsh;
  logic [CNW-1:0] cnt;
  logic           fall_ev, rise_ev;

  assign fall_ev = busy && (master ? (tick && sclk_o)  : ext_fall);
  assign rise_ev = busy && (master ? (tick && !sclk_o) : ext_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsh    <= '1;
      rsh    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      sclk_o <= 1'b1;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        tsh    <= data;
        busy   <= 1'b1;
        cnt    <= '0;
        sclk_o <= 1'b1;
      end else if (fall_ev) begin
        if (master) sclk_o <= 1'b0;
        if (cnt != '0) tsh <= {1'b1, tsh[DW-1:1]};
      end else if (rise_ev) begin
        if (master) sclk_o <= 1'b1;
        rsh <= {rxd, rsh[DW-1:1]};
        if (cnt == CNW'(DW - 1)) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= {rxd, rsh[DW-1:1]};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? tsh[0] : 1'b1;

  assert_sclk_rests_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);
  assert_done_ends_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/sio_channel.sv
module sio_channel
  import sio_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OS_LO       = 8,
  parameter int OS_HI       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_ext_clk_i,
  input  logic          cfg_div8_i,
  output logic [1:0]    cfg_mode_o,
  output logic          cfg_ext_clk_o,
  output logic          cfg_div8_o,
  input  logic          baud_tick,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sclk_oe,
  output logic          txd,
  input  logic          rxd,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          frame_err,
  output logic          overrun
);
  sio_mode_e mode_q;
  logic      ext_q, div8_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_ASYNC8;
      ext_q  <= 1'b0;
      div8_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= sio_mode_e'(cfg_mode_i);
      ext_q  <= cfg_ext_clk_i;
      div8_q <= cfg_div8_i;
    end
  end

  assign cfg_mode_o    = mode_q;
  assign cfg_ext_clk_o = ext_q;
  assign cfg_div8_o    = div8_q;

  logic rxd_s, rxd_p, sck_s, sck_p;
  sio_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s), .q_prev(rxd_p));
  sio_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk_in), .q(sck_s), .q_prev(sck_p));

  logic rxd_fall, sck_rise, sck_fall, is_async, seven, master, async_tick, accept;
  assign rxd_fall   = rxd_p && !rxd_s;
  assign sck_rise   = sck_s && !sck_p;
  assign sck_fall   = sck_p && !sck_s;
  assign is_async   = mode_is_async(mode_q);
  assign seven      = (mode_q == MODE_ASYNC7);
  assign master     = (mode_q == MODE_SYNC_MASTER);
  assign async_tick = ext_q ? sck_rise : baud_tick;
  assign accept     = tx_valid && tx_ready;

  logic          atx_busy, atx_txd, arx_done, arx_ferr;
  logic [DW-1:0] arx_data;
  logic          sy_busy, sy_txd, sy_done;
  logic [DW-1:0] sy_rdata;

  sio_async_tx #(.DW(DW), .OS_LO(OS_LO), .OS_HI(OS_HI)) u_atx (
    .clk(clk), .rst_n(rst_n), .tick(async_tick), .div8(div8_q), .seven(seven),
    .start(accept && is_async), .data(tx_data), .busy(atx_busy), .txd(atx_txd));

  sio_async_rx #(.DW(DW), .OS_LO(OS_LO), .OS_HI(OS_HI)) u_arx (
    .clk(clk), .rst_n(rst_n), .en(is_async), .tick(async_tick), .div8(div8_q),
    .seven(seven), .rxd(rxd_s), .rxd_fall(rxd_fall), .done(arx_done),
    .ferr(arx_ferr), .data(arx_data));

  sio_sync_eng #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .master(master), .tick(baud_tick),
    .ext_rise(sck_rise), .ext_fall(sck_fall), .rxd(rxd_s),
    .start(accept && !is_async), .data(tx_data), .busy(sy_busy), .txd(sy_txd),
    .sclk_o(sclk_out), .done(sy_done), .rdata(sy_rdata));

  assign tx_ready = is_async ? !atx_busy : !sy_busy;
  assign txd      = is_async ? atx_txd : sy_txd;
  assign sclk_oe  = master;

  logic rdone;
  assign rdone = arx_done || sy_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rdone) begin
        rx_valid <= 1'b1;
        rx_data  <= arx_done ? arx_data : sy_rdata;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (cfg_wr) begin
        frame_err <= 1'b0;
        overrun   <= 1'b0;
      end else begin
        if (arx_done && arx_ferr)           frame_err <= 1'b1;
        if (rdone && rx_valid && !rx_ready) overrun   <= 1'b1;
      end
    end
  end

  assert_accept_blocks_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_wr) |=> !tx_ready);
  assert_rx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rdone) |=> (rx_valid && $stable(rx_data)));
  assert_overrun_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid));
  assert_async_idle_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_async && tx_ready) |-> txd);
endmodule

// File: tb/tb_sio_channel.sv
module tb_sio_channel;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int EXT_HALF   = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_ext_clk_i = 1'b0, cfg_div8_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'b11, cfg_mode_o;
  logic       cfg_ext_clk_o, cfg_div8_o;
  logic       baud_tick = 1'b0, sclk_in, sclk_out, sclk_oe, txd, rxd;
  logic       tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic       frame_err, overrun;

  logic ext_gen = 1'b1, ext_run = 1'b0, sclk_man = 1'b1;
  logic loop = 1'b0, rxd_drv = 1'b1;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  assign sclk_in = ext_run ? ext_gen : sclk_man;
  assign rxd     = loop ? txd : rxd_drv;

  sio_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode_i(cfg_mode_i),
    .cfg_ext_clk_i(cfg_ext_clk_i), .cfg_div8_i(cfg_div8_i), .cfg_mode_o(cfg_mode_o),
    .cfg_ext_clk_o(cfg_ext_clk_o), .cfg_div8_o(cfg_div8_o), .baud_tick(baud_tick),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .rxd(rxd),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .frame_err(frame_err), .overrun(overrun));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  end

  initial forever begin
    repeat (EXT_HALF) @(negedge clk);
    ext_gen = ~ext_gen;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R13: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bitc(input logic e, input logic dv);
    return (dv ? 8 : 16) * (e ? 2 * EXT_HALF : TICK_DIV);
  endfunction

  task automatic set_cfg(input logic [1:0] m, input logic e, input logic dv);
    cfg_mode_i = m; cfg_ext_clk_i = e; cfg_div8_i = dv;
    cfg_wr = 1'b1;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) cyc(1);
    cyc(1);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      if (rx_valid) begin got = 1; break; end
      cyc(1);
    end
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    cyc(1);
    rx_ready = 1'b0;
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 4000 && !tx_ready; i++) cyc(1);
  endtask

  // async loopback; optional mid-bit check of the line (R4, R5, R6, R7)
  task automatic async_loop(input logic [7:0] d, input logic [1:0] m,
                            input logic e, input logic dv, input bit detail);
    int  b;
    int  nb;
    bit  got;
    logic [7:0] exp;
    b   = bitc(e, dv);
    nb  = (m == 2'b10) ? 7 : 8;
    exp = (m == 2'b10) ? (d & 8'h7F) : d;
    ext_run = e;
    loop    = 1'b1;
    if (cfg_mode_o != m || cfg_ext_clk_o != e || cfg_div8_o != dv) begin
      set_cfg(m, e, dv);
      cyc(8);
    end
    push(d);
    if (detail) begin
      for (int i = 0; i < 200 && txd; i++) cyc(1);
      cyc(b / 2);
      chk("R4 start bit low", txd, 0);
      for (int i = 0; i < nb; i++) begin
        cyc(b);
        chk("R4 R6 data bit LSB first", txd, d[i]);
      end
      cyc(b);
      chk("R4 R7 stop bit high after last data bit", txd, 1);
    end
    wait_rx(b * 14, got);
    chk("R5 R6 loopback word arrives", got, 1);
    chk("R7 loopback data", rx_data, exp);
    pop();
    wait_tx_idle();
    chk("R4 idle line high", txd, 1);
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nb, input logic stopv, input int b);
    rxd_drv = 1'b0;
    cyc(b);
    for (int i = 0; i < nb; i++) begin
      rxd_drv = d[i];
      cyc(b);
    end
    rxd_drv = stopv;
    cyc(b);
    rxd_drv = 1'b1;
    cyc(b);
  endtask

  initial begin
    bit got;
    int rises;
    logic prev;
    logic [7:0] mbytes [4];
    mbytes[0] = 8'hA5; mbytes[1] = 8'h3C; mbytes[2] = 8'h01; mbytes[3] = 8'h80;

    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 txd", txd, 1);
    chk("R1 sclk_oe", sclk_oe, 0);
    chk("R1 flags", {frame_err, overrun}, 0);
    chk("R1 cfg readback", {cfg_mode_o, cfg_ext_clk_o, cfg_div8_o}, 4'b1100);

    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int dv = 0; dv < 2; dv++) begin
          set_cfg(2'(m), 1'(e), 1'(dv));
          chk("R2 R3 cfg readback", {cfg_mode_o, cfg_ext_clk_o, cfg_div8_o},
              {2'(m), 1'(e), 1'(dv)});
          chk("R11 sclk_oe only in master mode (R3 00)", sclk_oe, (m == 0));
        end
    set_cfg(2'b11, 1'b0, 1'b1);
    cyc(8);

    async_loop(8'h96, 2'b11, 1'b0, 1'b1, 1);
    async_loop(8'h4B, 2'b11, 1'b0, 1'b0, 1);
    async_loop(8'h55, 2'b10, 1'b0, 1'b1, 1);
    async_loop(8'hD5, 2'b10, 1'b0, 1'b1, 1);
    async_loop(8'hC3, 2'b11, 1'b1, 1'b1, 1);
    async_loop(8'h3A, 2'b10, 1'b1, 1'b0, 1);
    async_loop(8'hFF, 2'b10, 1'b0, 1'b1, 0);
    for (int v = 0; v < 256; v++) async_loop(8'(v), 2'b11, 1'b0, 1'b1, 0);
    ext_run = 1'b0;
    loop    = 1'b0;

    set_cfg(2'b11, 1'b0, 1'b1);
    cyc(8);
    rxd_drv = 1'b0;
    cyc(6);
    rxd_drv = 1'b1;
    cyc(120);
    chk("R8 short low pulse rejected", rx_valid, 0);
    drive_frame(8'h3C, 8, 1'b1, 32);
    chk("R8 frame after glitch", {rx_valid, rx_data}, {1'b1, 8'h3C});
    chk("R9 good stop no frame_err", frame_err, 0);
    pop();

    drive_frame(8'h5A, 7, 1'b1, 32);
    set_cfg(2'b10, 1'b0, 1'b1);
    cyc(8);
    drive_frame(8'hDA, 7, 1'b1, 32);
    chk("R7 rx 7-bit msb zero", {rx_valid, rx_data}, {1'b1, 8'h5A});
    pop();

    set_cfg(2'b11, 1'b0, 1'b1);
    cyc(8);
    drive_frame(8'hA5, 8, 1'b0, 32);
    chk("R9 frame_err set", frame_err, 1);
    chk("R9 word delivered", {rx_valid, rx_data}, {1'b1, 8'hA5});
    pop();
    set_cfg(2'b11, 1'b0, 1'b1);
    chk("R2 write clears frame_err", frame_err, 0);

    drive_frame(8'h11, 8, 1'b1, 32);
    chk("R10 no overrun on first word", overrun, 0);
    drive_frame(8'h22, 8, 1'b1, 32);
    chk("R10 overrun set", overrun, 1);
    chk("R10 newest word held", {rx_valid, rx_data}, {1'b1, 8'h22});
    pop();
    chk("R13 pop clears rx_valid", rx_valid, 0);
    set_cfg(2'b11, 1'b0, 1'b1);
    chk("R2 write clears overrun", overrun, 0);

    set_cfg(2'b00, 1'b0, 1'b0);
    loop = 1'b1;
    cyc(8);
    chk("R11 master drives clock", sclk_oe, 1);
    chk("R11 clock rests high", sclk_out, 1);
    foreach (mbytes[k]) begin
      push(mbytes[k]);
      chk("R13 busy after accept", tx_ready, 0);
      rises = 0;
      prev  = sclk_out;
      for (int i = 0; i < 400 && !rx_valid; i++) begin
        cyc(1);
        if (sclk_out && !prev) rises++;
        prev = sclk_out;
      end
      chk("R11 eight rising edges", rises, 8);
      chk("R11 master loopback data", {rx_valid, rx_data}, {1'b1, mbytes[k]});
      chk("R11 clock back high", sclk_out, 1);
      pop();
      cyc(4);
    end
    loop = 1'b0;

    set_cfg(2'b01, 1'b0, 1'b0);
    sclk_man = 1'b1;
    cyc(8);
    chk("R12 slave leaves clock undriven", sclk_oe, 0);
    begin
      logic [7:0] t, r;
      t = 8'hB4; r = 8'h6D;
      push(t);
      for (int i = 0; i < 8; i++) begin
        sclk_man = 1'b0;
        cyc(8);
        chk("R12 slave txd bit", txd, t[i]);
        rxd_drv = r[i];
        cyc(8);
        sclk_man = 1'b1;
        cyc(8);
      end
      chk("R12 slave word received", {rx_valid, rx_data}, {1'b1, r});
      chk("R13 tx_ready after slave word", tx_ready, 1);
      pop();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule